// File: doc/BRIEF.md
# 2D Mesh Output Port Selector

This block decides, for one router of a two-dimensional mesh, which of five outputs a packet header leaves by: west, east, south, north, or the local processor. The header carries signed relative offsets in x and y. Each offset is the destination coordinate minus the current coordinate. Along with the port, the block produces the offsets for the next hop. The offset of the dimension that was travelled is moved one unit toward zero. The decision is registered, so the result appears one clock after the header is presented.

Two routing modes are available, selected per header by a mode bit that is sampled together with the header. The deterministic mode finishes all x travel before any y travel. The west-first mode completes every westward hop first. Once no westward travel remains, it chooses among the productive ports (east, south, north) using per-port busy inputs. It never turns back into west and never takes a hop that moves away from the destination.

Top module: `mesh_port_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0, out_port is 0 and both output offsets are 0.
- R2: out_valid equals in_valid of the previous cycle. When out_valid is 1, exactly one bit of out_port is set. Port bit positions are: bit0 local, bit1 west, bit2 east, bit3 south, bit4 north. When in_valid is 0, out_port, out_dx and out_dy keep their previous values.
- R3: When dx is negative, west is selected in both modes, whatever the busy inputs are.
- R4: When dx and dy are both zero, local is selected and both offsets pass through unchanged.
- R5: In deterministic mode (in_mode=0) with dx positive, east is selected, whatever the busy inputs are.
- R6: In deterministic mode with dx zero, south is selected when dy is negative and north when dy is positive.
- R7: In west-first mode (in_mode=1) with dx not negative, the first productive port whose busy bit is 0 is selected. The order is east (when dx>0), then the y port (south when dy<0, north when dy>0). in_busy uses the same bit positions as out_port.
- R8: In west-first mode, when every productive port is busy, east is selected if dx>0; otherwise the y port is selected.
- R9: Only productive ports are ever selected. The busy bits for west and local have no effect.
- R10: Offsets step toward zero by one in the travelled dimension: west adds 1 to dx, east subtracts 1 from dx, south adds 1 to dy, north subtracts 1 from dy. The other offset passes through unchanged.
- R11: The mode applies only to the header it arrives with. Back-to-back headers with different modes are each routed by their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present this cycle |
| in_mode | input | 1 | 0 deterministic, 1 west-first |
| in_dx | input | W | Signed x offset (destination minus here) |
| in_dy | input | W | Signed y offset |
| in_busy | input | 5 | Per-port congestion, same bit positions as out_port |
| out_valid | output | 1 | Decision valid |
| out_port | output | 5 | One-hot selected port |
| out_dx | output | W | x offset for the next hop |
| out_dy | output | W | y offset for the next hop |

## Verification
The hardest situation to reach is a west-first header in which every productive port is busy while the unproductive ports are free. This case exposes both a wrong fallback choice and any leak of a non-minimal port. Random stimulus reaches it rarely, because offsets spread over the full signed range seldom pair up with matching busy patterns. For that reason, most random headers draw offsets from a small window around zero and busy patterns with a bias toward all-busy. Directed headers add the all-busy, full-range and back-to-back mode-switch cases.

// File: rtl/mesh_port_sel.sv
module mesh_port_sel #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_mode,
  input  logic signed [W-1:0] in_dx,
  input  logic signed [W-1:0] in_dy,
  input  logic [4:0]          in_busy,
  output logic                out_valid,
  output logic [4:0]          out_port,
  output logic signed [W-1:0] out_dx,
  output logic signed [W-1:0] out_dy
);
  localparam logic [4:0] P_LOCAL = 5'b00001;
  localparam logic [4:0] P_WEST  = 5'b00010;
  localparam logic [4:0] P_EAST  = 5'b00100;
  localparam logic [4:0] P_SOUTH = 5'b01000;
  localparam logic [4:0] P_NORTH = 5'b10000;
  localparam logic signed [W-1:0] ONE = 1;

  logic x_neg, x_pos, y_neg, y_pos;
  logic [4:0] prod, freep, dflt, sel;
  logic signed [W-1:0] nx, ny;

  assign x_neg = in_dx < 0;
  assign x_pos = in_dx > 0;
  assign y_neg = in_dy < 0;
  assign y_pos = in_dy > 0;
  assign prod  = {y_pos, y_neg, x_pos, 2'b00};
  assign freep = prod & ~in_busy;
  assign dflt  = x_pos ? P_EAST : (y_neg ? P_SOUTH : P_NORTH);

  always_comb begin
    if (x_neg)                                sel = P_WEST;
    else if (!(x_pos || y_neg || y_pos))      sel = P_LOCAL;
    else if (!in_mode || freep == 5'b00000)   sel = dflt;
    else if (freep[2])                        sel = P_EAST;
    else if (freep[3])                        sel = P_SOUTH;
    else                                      sel = P_NORTH;
  end

  assign nx = sel[1] ? in_dx + ONE : (sel[2] ? in_dx - ONE : in_dx);
  assign ny = sel[3] ? in_dy + ONE : (sel[4] ? in_dy - ONE : in_dy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_dx    <= '0;
      out_dy    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port <= sel;
        out_dx   <= nx;
        out_dy   <= ny;
      end
    end
  end
endmodule

module mesh_port_sel_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_mode,
  input logic signed [W-1:0] in_dx,
  input logic signed [W-1:0] in_dy,
  input logic [4:0]          in_busy,
  input logic                out_valid,
  input logic [4:0]          out_port,
  input logic signed [W-1:0] out_dx,
  input logic signed [W-1:0] out_dy
);
  localparam logic signed [W-1:0] ONE = 1;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_port) == 1);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> ($stable(out_port) && $stable(out_dx) && $stable(out_dy)));
  a_r3_west_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dx < 0) |=> out_port == 5'b00010);
  a_r4_local: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dx == 0 && in_dy == 0) |=> (out_port == 5'b00001 && out_dx == 0 && out_dy == 0));
  a_r5_det_east: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode && in_dx > 0) |=> out_port == 5'b00100);
  a_r9_no_west_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dx >= 0) |=> !out_port[1]);
  a_r10_east_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dx > 0 && !in_mode) |=> out_dx == $past(in_dx) - ONE);
endmodule

bind mesh_port_sel mesh_port_sel_chk #(.W(W)) u_chk (.*);

// File: tb/mesh_port_sel_tb.sv
module mesh_port_sel_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0;
  logic signed [W-1:0] in_dx = '0, in_dy = '0;
  logic [4:0] in_busy = '0;
  logic out_valid;
  logic [4:0] out_port;
  logic signed [W-1:0] out_dx, out_dy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mesh_port_sel #(.W(W)) u_dut (.*);

  function automatic logic [4:0] exp_port(bit m, int dx, int dy, logic [4:0] b);
    logic [4:0] d;
    if (dx < 0) return 5'b00010;
    if (dx == 0 && dy == 0) return 5'b00001;
    d = (dx > 0) ? 5'b00100 : ((dy < 0) ? 5'b01000 : 5'b10000);
    if (!m) return d;
    if (dx > 0 && !b[2]) return 5'b00100;
    if (dy < 0 && !b[3]) return 5'b01000;
    if (dy > 0 && !b[4]) return 5'b10000;
    return d;
  endfunction

  function automatic string tag_of(bit m, int dx, int dy, logic [4:0] b);
    if (dx < 0) return "R3";
    if (dx == 0 && dy == 0) return "R4";
    if (!m) return (dx > 0) ? "R5" : "R6";
    if ((dx <= 0 || b[2]) && (dy >= 0 || b[3]) && (dy <= 0 || b[4])) return "R8";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit m, int dx, int dy, logic [4:0] b);
    logic [4:0] ep;
    int ex, ey;
    string t;
    in_valid = 1'b1; in_mode = m; in_dx = W'(dx); in_dy = W'(dy); in_busy = b;
    @(negedge clk);
    ep = exp_port(m, dx, dy, b);
    t = tag_of(m, dx, dy, b);
    ex = dx + (ep[1] ? 1 : 0) - (ep[2] ? 1 : 0);
    ey = dy + (ep[3] ? 1 : 0) - (ep[4] ? 1 : 0);
    chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
    chk(out_port == ep, t, int'(out_port), int'(ep));
    chk(out_dx == ex && out_dy == ey, "R10", int'(out_dx) * 1000 + int'(out_dy), ex * 1000 + ey);
    chk(!((out_port[2] && dx <= 0) || (out_port[3] && dy >= 0) || (out_port[4] && dy <= 0) || out_port[1] && dx >= 0),
        "R9", int'(out_port), int'(ep));
  endtask

  task automatic idle();
    logic [4:0] p;
    logic signed [W-1:0] x, y;
    p = out_port; x = out_dx; y = out_dy;
    in_valid = 1'b0; in_dx = W'($urandom); in_dy = W'($urandom); in_busy = 5'($urandom);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    chk(out_port == p && out_dx == x && out_dy == y, "R2", int'(out_port), int'(p));
  endtask

  function automatic int small_off();
    return int'($urandom_range(0, 8)) - 4;
  endfunction

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk); @(negedge clk);
    chk(out_valid == 0 && out_port == 0 && out_dx == 0 && out_dy == 0, "R1", int'(out_port), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_port == 0 && out_dx == 0 && out_dy == 0, "R1", int'(out_port), 0);
    send(0, 0, 0, 5'b11111);
    send(1, 0, 0, 5'b00000);
    send(1, -5, 3, 5'b11111);
    send(0, -128, 127, 5'b00000);
    send(0, 3, -2, 5'b00100);
    send(0, 0, -4, 5'b01000);
    send(0, 0, 7, 5'b10000);
    send(1, 2, 3, 5'b00100);
    send(1, 2, -1, 5'b11111);
    send(1, 0, -2, 5'b01000);
    send(1, 2, 0, 5'b00100);
    send(1, 1, 1, 5'b00011);
    send(1, 127, -128, 5'b00100);
    send(0, 3, 3, 5'b00100);
    send(1, 3, 3, 5'b00100);
    chk(out_port == 5'b10000, "R11", int'(out_port), 16);
    idle();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else if ($urandom_range(0, 4) == 0)
        send(1'($urandom), int'($signed(W'($urandom))), int'($signed(W'($urandom))), 5'($urandom));
      else
        send(1'($urandom), small_off(), small_off(),
             ($urandom_range(0, 2) == 0) ? 5'b11100 : 5'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule